// File: doc/BRIEF.md
# Goldilocks Field Multiplier

This block multiplies two elements of the prime field with modulus p = 2^64 - 2^32 + 1 and returns the product fully reduced into the range [0, p). It is built as a two-stage pipeline. The first stage registers the full 128-bit integer product. The second stage folds the upper half of that product back into the lower half and registers the reduced result. The fold relies on the special shape of p and needs no general-purpose modular reducer.

Operands enter on a valid/ready stream and results leave on another valid/ready stream. When the consumer holds `out_ready` high, a new operand pair can enter on every cycle, and each result appears exactly two cycles after its operands were accepted.

Back-pressure stalls the whole pipeline as one unit. While a result is waiting and `out_ready` is low, `in_ready` is low, and both the waiting result and the in-flight operands stay where they are. Operands must already be reduced, that is, less than p.

Top module: `gl_modmul`

## Requirements
- R1: For any operands a, b < p that are accepted, the result later delivered equals (a*b) mod p. Results come out in the order their operands were accepted.
- R2: The operand pair (p-1, p-1) yields 1.
- R3: Any operand multiplied by 0, on either side, yields 0.
- R4: Whenever `out_valid` is high, `out_data` is less than p.
- R5: With `out_ready` held high, a pair accepted at clock edge k (`in_valid` and `in_ready` both high) is presented with `out_valid` high after edge k+2.
- R6: Whenever `out_ready` is high, `in_ready` is high, so back-to-back pairs are accepted every cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next cycle, and no result is lost or duplicated.
- R8: `rst` is synchronous and active high. After a cycle with `rst` high, `out_valid` is low and every operand pair in flight is discarded.
- R9: Products whose upper half drives the fold through its borrow and carry corrections are exact. For example, 2^32 * 2^32 yields 2^32 - 1, and 2^48 * 2^48 yields p - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block accepts the pair at this edge |
| in_a | input | 64 | First operand, less than p |
| in_b | input | 64 | Second operand, less than p |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_data | output | 64 | Reduced product |

## Verification
Each result is due two clock edges after its operands are accepted while the consumer stays ready. The bench tags every accepted pair with its cycle number and checks that the arrival cycle is exactly two later during free-flowing phases. In stall phases the bench relaxes timing to strict in-order matching and checks that a held result stays stable. It samples at the falling edge, after the inputs for the coming edge are applied, so that each handshake is counted in the cycle it takes effect.

// File: rtl/gl_pkg.sv
package gl_pkg;
  localparam int unsigned EW = 64;
  localparam int unsigned HW = EW / 2;
  localparam int unsigned PW = 2 * EW;
  localparam logic [EW-1:0] GL_P   = 64'hFFFF_FFFF_0000_0001;
  localparam logic [EW-1:0] GL_EPS = 64'h0000_0000_FFFF_FFFF; // 2^64 mod p
  typedef logic [EW-1:0] elem_t;
  typedef logic [PW-1:0] prod_t;
endpackage

// File: rtl/gl_pipe_ctl.sv
module gl_pipe_ctl #(
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              advance,
  output logic [STAGES-1:0] stage_v
);
  logic [STAGES-1:0] v_q;

  // the whole pipe moves unless the last stage holds a result nobody takes
  assign advance = !v_q[STAGES-1] || out_ready;
  assign stage_v = v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else if (advance) begin
      v_q <= {v_q[STAGES-2:0], in_valid};
    end
  end
endmodule

// File: rtl/gl_mul_stage.sv
module gl_mul_stage
  import gl_pkg::*;
(
  input  logic  clk,
  input  logic  load,
  input  elem_t op_a,
  input  elem_t op_b,
  output prod_t prod
);
  prod_t prod_q;

  always_ff @(posedge clk) begin
    if (load) prod_q <= prod_t'(op_a) * prod_t'(op_b);
  end

  assign prod = prod_q;
endmodule

// File: rtl/gl_fold.sv
module gl_fold
  import gl_pkg::*;
(
  input  prod_t prod,
  output elem_t res
);
  elem_t           lo, hi, t0, t1, r;
  logic [HW-1:0]   hh, hl;
  logic [EW:0]     diff, sum;

  always_comb begin
    lo = prod[EW-1:0];
    hi = prod[PW-1:EW];
    hh = hi[EW-1:HW];
    hl = hi[HW-1:0];
    // 2^96 = -1 mod p: subtract the top quarter, borrow repaired by adding p
    diff = {1'b0, lo} - {{(EW-HW+1){1'b0}}, hh};
    t0   = diff[EW] ? (diff[EW-1:0] + GL_P) : diff[EW-1:0];
    // 2^64 = 2^32 - 1 mod p: middle quarter times (2^32 - 1)
    t1   = {hl, {HW{1'b0}}} - {{HW{1'b0}}, hl};
    sum  = {1'b0, t0} + {1'b0, t1};
    r    = sum[EW] ? (sum[EW-1:0] + GL_EPS) : sum[EW-1:0];
    res  = (r >= GL_P) ? (r - GL_P) : r;
  end
endmodule

// File: rtl/gl_modmul.sv
module gl_modmul
  import gl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_a,
  input  logic [63:0] in_b,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data
);
  localparam int unsigned NSTAGE = 2;

  logic              advance;
  logic [NSTAGE-1:0] stage_v;
  prod_t             prod;
  elem_t             reduced;
  elem_t             res_q;

  gl_pipe_ctl #(.STAGES(NSTAGE)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .advance   (advance),
    .stage_v   (stage_v)
  );

  gl_mul_stage u_mul (
    .clk  (clk),
    .load (advance && in_valid),
    .op_a (in_a),
    .op_b (in_b),
    .prod (prod)
  );

  gl_fold u_fold (
    .prod (prod),
    .res  (reduced)
  );

  always_ff @(posedge clk) begin
    if (advance && stage_v[0]) res_q <= reduced;
  end

  assign in_ready  = advance;
  assign out_valid = stage_v[NSTAGE-1];
  assign out_data  = res_q;
endmodule

// File: rtl/gl_modmul_chk.sv
module gl_modmul_chk
  import gl_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data
);
  AST_OUT_REDUCED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data < GL_P)); // R4
  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid); // R5
  AST_READY_PASS: assert property (@(posedge clk) disable iff (rst)
    out_ready |-> in_ready); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid); // R8
endmodule

bind gl_modmul gl_modmul_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/gl_modmul_tb.sv
module gl_modmul_tb;
  localparam logic [63:0] P = 64'hFFFF_FFFF_0000_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int          n_checks = 0;
  int          n_fails  = 0;
  int          cyc      = 0;
  bit          lat_chk  = 1'b1;
  bit          held     = 1'b0;
  logic [63:0] held_data;
  logic [63:0] exp_q[$];
  int          cyc_q[$];
  string       tag_q[$];

  gl_modmul u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] w;
    w = {64'd0, a} * {64'd0, b};
    return 64'(w % {64'd0, P});
  endfunction

  function automatic logic [63:0] rnd_elem();
    logic [63:0] v;
    int unsigned m;
    m = $urandom % 8;
    v = {$urandom, $urandom};
    if (m == 0) v = P - 64'd1 - 64'($urandom % 16);
    else if (m == 1) v = 64'($urandom % 16);
    else if (m == 2) v = 64'd1 << ($urandom % 64);
    if (v >= P) v = v - P;
    return v;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, then account for the handshakes of the coming edge
  task automatic step(input logic iv, input logic [63:0] a, input logic [63:0] b,
                      input logic ordy, input string tag);
    @(negedge clk);
    in_valid = iv; in_a = a; in_b = b; out_ready = ordy;
    #1;
    if (held) begin
      check("R7 held valid", {63'd0, out_valid}, 64'd1);
      check("R7 held data", out_data, held_data);
    end
    held = out_valid && !out_ready;
    held_data = out_data;
    if (out_ready) check("R6 ready pass", {63'd0, in_ready}, 64'd1);
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected result", 64'd1, 64'd0);
      end else begin
        check({tag_q[0], " product"}, out_data, exp_q[0]);
        check("R4 range", {63'd0, out_data < P}, 64'd1);
        if (lat_chk) check("R5 latency", 64'(cyc - cyc_q[0]), 64'd2);
        void'(exp_q.pop_front()); void'(cyc_q.pop_front()); void'(tag_q.pop_front());
      end
    end
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_mul(a, b));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) step(1'b0, '0, '0, 1'b1, "R1");
    check("R1 all results delivered", 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    check("R8 reset out_valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R8 idle in_ready", {63'd0, in_ready}, 64'd1);

    step(1'b1, P - 64'd1, P - 64'd1, 1'b1, "R2");
    check("R2 reference", ref_mul(P - 64'd1, P - 64'd1), 64'd1);
    step(1'b1, 64'd0, P - 64'd1, 1'b1, "R3");
    step(1'b1, 64'h1234_5678_9ABC_DEF0, 64'd0, 1'b1, "R3");
    step(1'b1, 64'd1 << 32, 64'd1 << 32, 1'b1, "R9");
    step(1'b1, 64'd1 << 48, 64'd1 << 48, 1'b1, "R9");
    check("R9 reference", ref_mul(64'd1 << 48, 64'd1 << 48), P - 64'd1);
    step(1'b1, P - 64'd1, 64'd2, 1'b1, "R9");
    step(1'b1, 64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_0000_0000, 1'b1, "R9");
    drain();

    for (int i = 0; i < 300; i++) step(1'b1, rnd_elem(), rnd_elem(), 1'b1, "R1");
    drain();

    lat_chk = 1'b0;
    for (int i = 0; i < 400; i++)
      step(1'(($urandom % 4) != 0), rnd_elem(), rnd_elem(), 1'(($urandom % 3) == 0), "R7");
    drain();
    lat_chk = 1'b1;

    step(1'b1, rnd_elem(), rnd_elem(), 1'b1, "R8");
    step(1'b1, rnd_elem(), rnd_elem(), 1'b1, "R8");
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); cyc_q.delete(); tag_q.delete();
    #1;
    check("R8 flushed after reset", {63'd0, out_valid}, 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check("R8 stays empty", {63'd0, out_valid}, 64'd0);
    end

    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule